// File: doc/BRIEF.md
# Converter Phase Sequencer with Result Summing

This block drives the control side of a successive-approximation converter. One accepted start runs one or more conversions of a single channel. Each conversion has up to three phases, always in the same order. The first is an optional assist phase, which pulls the sampling capacitor to the high reference or to the low reference. The second is a sampling window of fixed length. The third is a conversion phase that ends when the converter model returns its done pulse with a 12-bit code. The assist phase makes an open input wire visible: a broken input keeps the forced level instead of showing the real signal.

In summing mode the same channel is converted two, three or four times in a row, and the codes are added in a 14-bit accumulator. The assist and sampling phases run again before every conversion. After the last code arrives, the sum is stored, a one-cycle completion strobe is raised, and the block returns to idle. The channel select covers both the external inputs and the internal reference input. All channel codes are treated the same way.

Top module: `adc_seq_accum`

## Requirements
- R1: While reset is asserted and just after it, `busy_o`, `done_o`, `assist_en_o`, `assist_hi_o`, `sample_o` and `convert_o` are 0, and `result_o` is 0.
- R2: With an assist length N from 1 to 15, `assist_en_o` is high for exactly N cycles before each sampling window. With N = 0 the assist phase is skipped, and `sample_o` is high in the first cycle after the start is accepted.
- R3: While `assist_en_o` is high, `assist_hi_o` equals the polarity latched at start (1 = precharge to the high reference, 0 = discharge to the low reference). `assist_hi_o` is 0 whenever `assist_en_o` is 0.
- R4: At most one of `assist_en_o`, `sample_o` and `convert_o` is high in any cycle, and `convert_o` only rises directly after a sampling window.
- R5: Every sampling window lasts exactly SAMPLE_CYC (default 30) cycles.
- R6: `convert_o` stays high until `conv_done_i` is seen. A `conv_done_i` pulse outside the conversion phase is ignored.
- R7: The addition count code c (0 to 3) runs c+1 conversions, and `result_o` equals the sum of the returned codes.
- R8: The assist phase, with its full length, comes before every conversion of a multi-conversion run.
- R9: The 14-bit result holds the sum of four full-scale codes (4 × 0xFFF = 0x3FFC) without wrapping.
- R10: `done_o` is a single-cycle pulse in the cycle after the last done pulse. `result_o` changes only in that cycle, and a new start does not disturb it.
- R11: `busy_o` is high from the cycle after an accepted start until `done_o` rises. A start received while busy is ignored.
- R12: `chan_o` shows the channel latched at start and stays steady while busy, even if `chan_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| chan_i | input | CH_W | Channel to convert (external input or internal reference) |
| assist_len_i | input | ASSIST_W | Assist phase length in cycles, 0 = skip |
| assist_pol_i | input | 1 | Assist level: 1 = high-reference precharge, 0 = low-reference discharge |
| add_cnt_i | input | 2 | Number of conversions minus one (0..3) |
| conv_data_i | input | DATA_W | Code from the converter model |
| conv_done_i | input | 1 | Converter done pulse, qualifies `conv_data_i` |
| busy_o | output | 1 | Run in progress |
| assist_en_o | output | 1 | Assist phase active |
| assist_hi_o | output | 1 | Assist level select during the assist phase |
| sample_o | output | 1 | Sampling phase active |
| convert_o | output | 1 | Conversion phase active |
| chan_o | output | CH_W | Channel latched for the current run |
| result_o | output | DATA_W+2 | Stored sum of the last completed run |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench runs a single conversion with no assist phase. It then runs two to four conversions with short, medium and maximum assist lengths at both polarities. This separates a skipped phase from a phase of one cycle, and shows whether the assist phase runs again before every conversion. The returned codes change from one conversion to the next, so a sum that drops or repeats a code gives the wrong value. An all-full-scale run of four conversions exposes a truncated accumulator. One run sends a stray start and a stray done pulse during the sampling window, and changes the channel input while busy, to show that none of them is taken up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ASSIST = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
// Loadable down-counter that times the assist and sampling phases.
module adc_seq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         last_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The phase ends on the cycle that holds the final count.
    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/adc_seq_acc.sv
// Sums the converter codes and stores the final sum.
module adc_seq_acc #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic              fin_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ACC_W-1:0]  result_o,
    output logic              done_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
        logic             done;
    } acc_t;

    acc_t q, d;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum    = q.acc + ACC_W'(data_i);
        d      = q;
        d.done = 1'b0;
        if (clr_i) begin
            d.acc = '0;
        end else if (add_i) begin
            d.acc = sum;
        end
        if (fin_i) begin
            d.res  = sum;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign result_o = q.res;
    assign done_o   = q.done;

endmodule

// File: rtl/adc_seq_ctrl.sv
// Phase state machine: assist -> sample -> convert, repeated per conversion.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int ASSIST_W   = 4,
    parameter int ADD_W      = 2,
    parameter int TMR_W      = 5,
    parameter int SAMPLE_CYC = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic [ASSIST_W-1:0] assist_len_i,
    input  logic                assist_pol_i,
    input  logic [ADD_W-1:0]    add_cnt_i,
    input  logic                conv_done_i,
    input  logic                tmr_last_i,
    output logic                tmr_load_o,
    output logic [TMR_W-1:0]    tmr_val_o,
    output logic                acc_clr_o,
    output logic                acc_add_o,
    output logic                acc_fin_o,
    output phase_e              phase_o,
    output logic                pol_o,
    output logic [CH_W-1:0]     chan_o
);

    localparam logic [TMR_W-1:0] SAMPLE_VAL = TMR_W'(SAMPLE_CYC);

    typedef struct packed {
        phase_e              ph;
        logic [ADD_W-1:0]    rem;
        logic [CH_W-1:0]     chan;
        logic [ASSIST_W-1:0] len;
        logic                pol;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d          = q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        acc_clr_o  = 1'b0;
        acc_add_o  = 1'b0;
        acc_fin_o  = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.chan     = chan_i;
                    d.len      = assist_len_i;
                    d.pol      = assist_pol_i;
                    d.rem      = add_cnt_i;
                    acc_clr_o  = 1'b1;
                    tmr_load_o = 1'b1;
                    if (assist_len_i != '0) begin
                        d.ph      = PH_ASSIST;
                        tmr_val_o = TMR_W'(assist_len_i);
                    end else begin
                        d.ph      = PH_SAMPLE;
                        tmr_val_o = SAMPLE_VAL;
                    end
                end
            end
            PH_ASSIST: begin
                if (tmr_last_i) begin
                    d.ph       = PH_SAMPLE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SAMPLE_VAL;
                end
            end
            PH_SAMPLE: begin
                if (tmr_last_i) begin
                    d.ph = PH_CONV;
                end
            end
            PH_CONV: begin
                if (conv_done_i) begin
                    acc_add_o = 1'b1;
                    if (q.rem == '0) begin
                        acc_fin_o = 1'b1;
                        d.ph      = PH_IDLE;
                    end else begin
                        d.rem      = q.rem - ADD_W'(1);
                        tmr_load_o = 1'b1;
                        if (q.len != '0) begin
                            d.ph      = PH_ASSIST;
                            tmr_val_o = TMR_W'(q.len);
                        end else begin
                            d.ph      = PH_SAMPLE;
                            tmr_val_o = SAMPLE_VAL;
                        end
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign phase_o = q.ph;
    assign pol_o   = q.pol;
    assign chan_o  = q.chan;

endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum
    import adc_seq_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int ASSIST_W   = 4,
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic [ASSIST_W-1:0] assist_len_i,
    input  logic                assist_pol_i,
    input  logic [1:0]          add_cnt_i,
    input  logic [DATA_W-1:0]   conv_data_i,
    input  logic                conv_done_i,
    output logic                busy_o,
    output logic                assist_en_o,
    output logic                assist_hi_o,
    output logic                sample_o,
    output logic                convert_o,
    output logic [CH_W-1:0]     chan_o,
    output logic [DATA_W+1:0]   result_o,
    output logic                done_o
);

    localparam int ADD_W   = 2;
    localparam int ACC_W   = DATA_W + ADD_W;
    localparam int TMR_MAX = max_u(SAMPLE_CYC, (1 << ASSIST_W) - 1);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;
    logic             acc_clr, acc_add, acc_fin;
    logic             pol;
    phase_e           phase;

    adc_seq_ctrl #(
        .CH_W      (CH_W),
        .ASSIST_W  (ASSIST_W),
        .ADD_W     (ADD_W),
        .TMR_W     (TMR_W),
        .SAMPLE_CYC(SAMPLE_CYC)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .assist_len_i(assist_len_i),
        .assist_pol_i(assist_pol_i),
        .add_cnt_i   (add_cnt_i),
        .conv_done_i (conv_done_i),
        .tmr_last_i  (tmr_last),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .acc_clr_o   (acc_clr),
        .acc_add_o   (acc_add),
        .acc_fin_o   (acc_fin),
        .phase_o     (phase),
        .pol_o       (pol),
        .chan_o      (chan_o)
    );

    adc_seq_timer #(
        .W(TMR_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(tmr_load),
        .val_i (tmr_val),
        .last_o(tmr_last)
    );

    adc_seq_acc #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
    ) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (acc_clr),
        .add_i   (acc_add),
        .fin_i   (acc_fin),
        .data_i  (conv_data_i),
        .result_o(result_o),
        .done_o  (done_o)
    );

    assign busy_o      = (phase != PH_IDLE);
    assign assist_en_o = (phase == PH_ASSIST);
    assign assist_hi_o = (phase == PH_ASSIST) && pol;
    assign sample_o    = (phase == PH_SAMPLE);
    assign convert_o   = (phase == PH_CONV);

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CH_W       = 4,
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done_i,
    input logic              busy_o,
    input logic              assist_en_o,
    input logic              assist_hi_o,
    input logic              sample_o,
    input logic              convert_o,
    input logic [CH_W-1:0]   chan_o,
    input logic [DATA_W+1:0] result_o,
    input logic              done_o
);

    localparam int RUN_W = $clog2(SAMPLE_CYC + 2);

    logic [RUN_W-1:0] samp_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_run <= '0;
        end else if (sample_o) begin
            samp_run <= samp_run + RUN_W'(1);
        end else begin
            samp_run <= '0;
        end
    end

    a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({assist_en_o, sample_o, convert_o}));

    a_r4_conv_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_o) |-> $past(sample_o));

    a_r3_level_only_in_assist: assert property (@(posedge clk) disable iff (!rst_n)
        !assist_en_o |-> !assist_hi_o);

    a_r5_sample_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> (samp_run == RUN_W'(SAMPLE_CYC)));

    a_r6_conv_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_o && !conv_done_i) |=> convert_o);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_result_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r11_busy_covers_phases: assert property (@(posedge clk) disable iff (!rst_n)
        (assist_en_o || sample_o || convert_o) |-> busy_o);

    a_r11_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r12_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(chan_o));

endmodule

bind adc_seq_accum adc_seq_chk #(
    .CH_W      (CH_W),
    .DATA_W    (DATA_W),
    .SAMPLE_CYC(SAMPLE_CYC)
) i_adc_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done_i(conv_done_i),
    .busy_o     (busy_o),
    .assist_en_o(assist_en_o),
    .assist_hi_o(assist_hi_o),
    .sample_o   (sample_o),
    .convert_o  (convert_o),
    .chan_o     (chan_o),
    .result_o   (result_o),
    .done_o     (done_o)
);

// File: tb/test_adc_seq_accum.sv
module test_adc_seq_accum;

    localparam int SAMPLE_CYC = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic [3:0]  assist_len_i = '0;
    logic        assist_pol_i = 1'b0;
    logic [1:0]  add_cnt_i = '0;
    logic [11:0] conv_data_i = '0;
    logic        conv_done_i = 1'b0;
    logic        busy_o, assist_en_o, assist_hi_o, sample_o, convert_o, done_o;
    logic [3:0]  chan_o;
    logic [13:0] result_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    adc_seq_accum i_adc_seq_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .assist_len_i(assist_len_i),
        .assist_pol_i(assist_pol_i),
        .add_cnt_i   (add_cnt_i),
        .conv_data_i (conv_data_i),
        .conv_done_i (conv_done_i),
        .busy_o      (busy_o),
        .assist_en_o (assist_en_o),
        .assist_hi_o (assist_hi_o),
        .sample_o    (sample_o),
        .convert_o   (convert_o),
        .chan_o      (chan_o),
        .result_o    (result_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R11 watchdog: actual=%0d expected=idle", busy_o);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic test_reset();
        check({busy_o, done_o, assist_en_o, assist_hi_o, sample_o, convert_o} == 6'b0,
              "R1", "outputs in reset",
              int'({busy_o, done_o, assist_en_o, assist_hi_o, sample_o, convert_o}), 0);
        check(result_o == 14'h0, "R1", "result in reset", int'(result_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1", "idle after reset", int'({busy_o, done_o}), 0);
    endtask

    // One full run; stray=1 injects a start, a done pulse and a channel change
    // during the first sampling window.
    task automatic run_seq(input logic [3:0] chan, input logic [3:0] len, input logic pol,
                           input logic [1:0] addc, input logic [11:0] base,
                           input logic [11:0] step, input bit stray);
        int          n;
        int          cnt;
        logic [13:0] exp_sum;
        logic [13:0] prev;
        logic [11:0] code;
        n       = int'(addc) + 1;
        exp_sum = '0;
        prev    = result_o;
        @(negedge clk);
        start_i      = 1'b1;
        chan_i       = chan;
        assist_len_i = len;
        assist_pol_i = pol;
        add_cnt_i    = addc;
        @(negedge clk);
        start_i      = 1'b0;
        chan_i       = ~chan;
        assist_len_i = ~len;
        assist_pol_i = ~pol;
        add_cnt_i    = ~addc;
        check(busy_o === 1'b1, "R11", "busy after start", int'(busy_o), 1);
        check(result_o == prev, "R10", "result kept across start", int'(result_o), int'(prev));
        for (int k = 0; k < n; k++) begin
            cnt = 0;
            while (assist_en_o) begin
                if (assist_hi_o !== pol)
                    check(1'b0, "R3", "assist level", int'(assist_hi_o), int'(pol));
                cnt++;
                @(negedge clk);
            end
            check(cnt == int'(len), (k == 0) ? "R2" : "R8", "assist length", cnt, int'(len));
            if (k == 0) check(1'b1, "R3", "assist level held", 0, 0);
            cnt = 0;
            while (sample_o) begin
                cnt++;
                if (stray && k == 0 && cnt == 10) begin
                    start_i     = 1'b1;
                    conv_done_i = 1'b1;
                    conv_data_i = 12'h7FF;
                end else begin
                    start_i     = 1'b0;
                    conv_done_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i     = 1'b0;
            conv_done_i = 1'b0;
            check(cnt == SAMPLE_CYC, stray ? "R6" : "R5", "sampling length", cnt, SAMPLE_CYC);
            check(convert_o === 1'b1, "R4", "convert follows sample", int'(convert_o), 1);
            check(chan_o == chan, "R12", "latched channel", int'(chan_o), int'(chan));
            repeat (3) @(negedge clk);
            check(convert_o === 1'b1, "R6", "convert waits for done", int'(convert_o), 1);
            code        = base + 12'(k) * step;
            conv_data_i = code;
            conv_done_i = 1'b1;
            exp_sum     = exp_sum + 14'(code);
            @(negedge clk);
            conv_done_i = 1'b0;
        end
        check(done_o === 1'b1, "R10", "done pulse", int'(done_o), 1);
        check(result_o == exp_sum, (exp_sum == 14'h3FFC) ? "R9" : "R7", "sum",
              int'(result_o), int'(exp_sum));
        check(busy_o === 1'b0, stray ? "R11" : "R11", "idle at done", int'(busy_o), 0);
        @(negedge clk);
        check(done_o === 1'b0, "R10", "done single cycle", int'(done_o), 0);
        repeat (4) @(negedge clk);
        check(result_o == exp_sum, "R10", "result steady", int'(result_o), int'(exp_sum));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_seq(4'd3,  4'd0,  1'b1, 2'd0, 12'h111, 12'h000, 1'b0); // R2 skip, R7 single
        run_seq(4'd7,  4'd5,  1'b1, 2'd1, 12'h222, 12'h101, 1'b0); // R8 two conversions
        run_seq(4'd2,  4'd15, 1'b0, 2'd2, 12'h5A0, 12'h0F3, 1'b1); // R6 R11 R12 strays
        run_seq(4'd15, 4'd1,  1'b1, 2'd3, 12'hFFF, 12'h000, 1'b0); // R9 full scale
        run_seq(4'd9,  4'd3,  1'b0, 2'd3, 12'h0A5, 12'h3C1, 1'b0); // R7 four conversions
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule